// File: doc/BRIEF.md
# Legacy Printer Port Host Register File

This block is the processor-facing register set of a classic parallel printer port. A host reaches it over a simple strobed bus: a two-bit offset, an eight-bit write bus, an active-low read strobe and an active-low write strobe. Both strobes may arrive without any timing relation to the system clock. They are synchronised inside the block, and everything else runs on a single clock. A write is committed when the write strobe returns high.

Offset 0 holds the byte that drives the printer data lines. Offset 1 reports the printer handshake inputs and a sticky bus-timeout flag. Offset 2 holds six control bits. A timeout watchdog measures each enhanced-mode (EPP) bus cycle and sets the flag if the cycle runs for the full timeout window, which is 10 µs at the configured clock rate.

The block contains two state machines:

- **Read tracker.** It has the states `B_IDLE` and `B_READ`. A falling read strobe moves it from `B_IDLE` to `B_READ` and loads the status snapshot at that moment. A rising read strobe moves it back to `B_IDLE`.
- **Timeout watchdog.** It has the states `T_IDLE`, `T_RUN` and `T_LATE`.
  - `T_IDLE` goes to `T_RUN` when a cycle starts while EPP mode is on.
  - `T_RUN` goes back to `T_IDLE` when the cycle completes or EPP mode is turned off.
  - `T_RUN` goes to `T_LATE` when the terminal count is reached. This transition raises the flag.
  - `T_LATE` goes to `T_IDLE` when the cycle completes or EPP mode is turned off.

Top module: `lpt_host_regs`

## Requirements
- R1: The offset-0 data register resets to 0x00. It loads `bus_wdata` when the write strobe rises with `bus_addr`=0. Its value appears unchanged, with no inversion, on `port_data_out`, and it changes at no other time.
- R2: A read of offset 0 returns the live `port_pins_in` levels when `epp_mode`=0. It returns the stored data register when `epp_mode`=1.
- R3: The offset-1 byte is captured when the read strobe falls. It stays constant on `bus_rdata` until the strobe rises, even if the inputs change in between.
- R4: The offset-1 byte is laid out as follows:
  - bit 7 is the inverse of `busy_in`
  - bit 6 is `ack_n_in`
  - bit 5 is `paper_end_in`
  - bit 4 is `select_in`
  - bit 3 is `err_n_in`
  - bits 2 and 1 are always 0
  - bit 0 is the timeout flag
- R5: The timeout flag becomes 1 when an EPP cycle has run for TIMEOUT_US microseconds without `epp_cycle_done` (2500 clocks at the default 250 MHz, 10 µs). It does not become 1 if the cycle completes earlier or if `epp_mode`=0.
- R6: Writing offset 1 with bit 0 set to 1 clears the flag in one write. Writing offset 1 with bit 0 set to 0 leaves the flag unchanged, and the other bits written to offset 1 are ignored.
- R7: The offset-2 control register keeps bits 5:0 of a write and drives them on `ctrl_out`. It resets to 0, and reads of it return 0 in bits 7:6.
- R8: Reset clears the data register, the control register and the timeout flag.
- R9: Writes to offset 3 change nothing, and reads of offset 3 return 0x00. `bus_rdata` is 0x00 whenever no read is in progress.
- R10: During an SPP read of offset 0, `bus_rdata` follows `port_pins_in` when the pins change while the strobe is held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register offset |
| bus_wdata | input | 8 | Write data, held until the write is committed |
| bus_rd_n | input | 1 | Active-low read strobe (asynchronous) |
| bus_wr_n | input | 1 | Active-low write strobe (asynchronous) |
| bus_rdata | output | 8 | Read data, 0 outside a read |
| epp_mode | input | 1 | 1 selects enhanced mode, 0 selects standard (SPP) mode |
| port_pins_in | input | 8 | Live levels on the printer data lines |
| port_data_out | output | 8 | Data register driven to the printer data lines |
| err_n_in | input | 1 | Printer error, active low |
| select_in | input | 1 | Printer on line |
| paper_end_in | input | 1 | Paper out |
| ack_n_in | input | 1 | Printer acknowledge, active low |
| busy_in | input | 1 | Busy line as seen at the pin |
| ctrl_out | output | 6 | Control register bits |
| epp_cycle_start | input | 1 | One-clock pulse when an EPP bus cycle begins |
| epp_cycle_done | input | 1 | One-clock pulse when the EPP handshake completes |

## Verification
Three situations separate the correct watchdog from a miscounting one or a mode-blind one:

- a cycle completed at 2000 clocks, before the window ends;
- a cycle left open for 2600 clocks, past the window;
- the same long cycle with EPP mode off.

Offset-0 reads are taken in both modes with the pins and the register set to different bytes, which shows which source is selected. Distinct walking bit patterns on each status input expose any swapped bit or missing inversion. Changing the inputs in the middle of one held read shows whether the snapshot is frozen for offset 1 and kept live for offset 0.

// File: rtl/lpt_pkg.sv
package lpt_pkg;

    localparam logic [1:0] OFS_DATA   = 2'd0;
    localparam logic [1:0] OFS_STATUS = 2'd1;
    localparam logic [1:0] OFS_CTRL   = 2'd2;

    typedef enum logic {
        B_IDLE,
        B_READ
    } bus_state_t;

    typedef enum logic [1:0] {
        T_IDLE,
        T_RUN,
        T_LATE
    } tmr_state_t;

    // Status byte: bit 7 inverted busy, then ack, paper end, select, error,
    // two constant-zero bits, and the timeout flag in bit 0.
    function automatic logic [7:0] pack_status(
        input logic busy_pin,
        input logic ack_n,
        input logic paper_end,
        input logic sel,
        input logic err_n,
        input logic flag
    );
        return {~busy_pin, ack_n, paper_end, sel, err_n, 2'b00, flag};
    endfunction

endpackage

// File: rtl/lpt_strobe_sync.sv
module lpt_strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_n_async,
    output logic strobe_n_sync,
    output logic strobe_fall,
    output logic strobe_rise
);

    // Extra stage at the top holds the previous synchronised value
    // for edge detection.
    logic [STAGES:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '1;
        end else begin
            chain_q <= {chain_q[STAGES-1:0], strobe_n_async};
        end
    end

    assign strobe_n_sync = chain_q[STAGES-1];
    assign strobe_fall   = ~chain_q[STAGES-1] &  chain_q[STAGES];
    assign strobe_rise   =  chain_q[STAGES-1] & ~chain_q[STAGES];

endmodule

// File: rtl/lpt_epp_timer.sv
module lpt_epp_timer
    import lpt_pkg::*;
#(
    parameter int TERM_CYCLES = 2500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic cyc_start,
    input  logic cyc_done,
    output logic expire
);

    localparam int CW = $clog2(TERM_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(TERM_CYCLES - 1);

    tmr_state_t state_q, state_d;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= T_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (state_q == T_RUN && state_d == T_RUN) begin
            cnt_q <= cnt_q + 1'b1;
        end else begin
            cnt_q <= '0;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            T_IDLE: begin
                if (enable && cyc_start) state_d = T_RUN;
            end
            T_RUN: begin
                if (!enable || cyc_done) state_d = T_IDLE;
                else if (cnt_q == LAST)  state_d = T_LATE;
            end
            T_LATE: begin
                if (!enable || cyc_done) state_d = T_IDLE;
            end
            default: state_d = T_IDLE;
        endcase
    end

    always_comb begin
        expire = 1'b0;
        unique case (state_q)
            T_RUN:   expire = enable && !cyc_done && (cnt_q == LAST);
            default: expire = 1'b0;
        endcase
    end

endmodule

// File: rtl/lpt_host_regs.sv
module lpt_host_regs
    import lpt_pkg::*;
#(
    parameter int CLK_FREQ_HZ = 250_000_000,
    parameter int TIMEOUT_US  = 10,
    parameter int SYNC_STAGES = 2,
    parameter int DW          = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    bus_addr,
    input  logic [DW-1:0] bus_wdata,
    input  logic          bus_rd_n,
    input  logic          bus_wr_n,
    output logic [DW-1:0] bus_rdata,
    input  logic          epp_mode,
    input  logic [DW-1:0] port_pins_in,
    output logic [DW-1:0] port_data_out,
    input  logic          err_n_in,
    input  logic          select_in,
    input  logic          paper_end_in,
    input  logic          ack_n_in,
    input  logic          busy_in,
    output logic [DW-3:0] ctrl_out,
    input  logic          epp_cycle_start,
    input  logic          epp_cycle_done
);

    localparam int CTRL_BITS   = DW - 2;
    localparam int TERM_CYCLES = (CLK_FREQ_HZ / 1_000_000) * TIMEOUT_US;

    logic rd_n_s, rd_fall, rd_rise;
    logic wr_n_s, wr_fall, wr_rise;
    logic wr_pulse, rd_active, tmr_expire;

    bus_state_t            bus_state_q, bus_state_d;
    logic [DW-1:0]         data_q;
    logic [CTRL_BITS-1:0]  ctrl_q;
    logic [DW-1:0]         snap_q;
    logic                  flag_q;

    lpt_strobe_sync #(.STAGES(SYNC_STAGES)) u_rd_sync (
        .clk            (clk),
        .rst_n          (rst_n),
        .strobe_n_async (bus_rd_n),
        .strobe_n_sync  (rd_n_s),
        .strobe_fall    (rd_fall),
        .strobe_rise    (rd_rise)
    );

    lpt_strobe_sync #(.STAGES(SYNC_STAGES)) u_wr_sync (
        .clk            (clk),
        .rst_n          (rst_n),
        .strobe_n_async (bus_wr_n),
        .strobe_n_sync  (wr_n_s),
        .strobe_fall    (wr_fall),
        .strobe_rise    (wr_rise)
    );

    lpt_epp_timer #(.TERM_CYCLES(TERM_CYCLES)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (epp_mode),
        .cyc_start (epp_cycle_start),
        .cyc_done  (epp_cycle_done),
        .expire    (tmr_expire)
    );

    // A write commits when the strobe returns high.
    assign wr_pulse = wr_rise;

    // Read tracker: state register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_state_q <= B_IDLE;
        end else begin
            bus_state_q <= bus_state_d;
        end
    end

    // Read tracker: next state.
    always_comb begin
        bus_state_d = bus_state_q;
        unique case (bus_state_q)
            B_IDLE: if (rd_fall) bus_state_d = B_READ;
            B_READ: if (rd_rise) bus_state_d = B_IDLE;
            default: bus_state_d = B_IDLE;
        endcase
    end

    // Read tracker: outputs.
    always_comb begin
        rd_active = 1'b0;
        unique case (bus_state_q)
            B_READ:  rd_active = 1'b1;
            default: rd_active = 1'b0;
        endcase
    end

    // Status snapshot, loaded on the transition into a read.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            snap_q <= '0;
        end else if (bus_state_q == B_IDLE && bus_state_d == B_READ) begin
            snap_q <= pack_status(busy_in, ack_n_in, paper_end_in,
                                  select_in, err_n_in, flag_q);
        end
    end

    // Data and control registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            ctrl_q <= '0;
        end else if (wr_pulse) begin
            if (bus_addr == OFS_DATA) data_q <= bus_wdata;
            if (bus_addr == OFS_CTRL) ctrl_q <= bus_wdata[CTRL_BITS-1:0];
        end
    end

    // Sticky timeout flag: setting wins over a clear in the same cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (tmr_expire) begin
            flag_q <= 1'b1;
        end else if (wr_pulse && bus_addr == OFS_STATUS && bus_wdata[0]) begin
            flag_q <= 1'b0;
        end
    end

    // Read data mux.
    always_comb begin
        bus_rdata = '0;
        if (rd_active) begin
            case (bus_addr)
                OFS_DATA:   bus_rdata = epp_mode ? data_q : port_pins_in;
                OFS_STATUS: bus_rdata = snap_q;
                OFS_CTRL:   bus_rdata = {2'b00, ctrl_q};
                default:    bus_rdata = '0;
            endcase
        end
    end

    assign port_data_out = data_q;
    assign ctrl_out      = ctrl_q;

endmodule

// File: rtl/lpt_host_regs_chk.sv
module lpt_host_regs_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] bus_addr,
    input logic [7:0] bus_wdata,
    input logic [7:0] bus_rdata,
    input logic       epp_mode,
    input logic [7:0] port_pins_in,
    input logic [7:0] port_data_out,
    input logic       rd_active,
    input logic       wr_pulse,
    input logic       tmr_expire,
    input logic       flag_q
);

    assert_data_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_pulse && bus_addr == 2'd0) |=> $stable(port_data_out));

    assert_spp_live_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_active && bus_addr == 2'd0 && !epp_mode) |-> bus_rdata == port_pins_in);

    assert_status_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_active && $past(rd_active) && bus_addr == 2'd1 && $past(bus_addr) == 2'd1)
        |-> $stable(bus_rdata));

    assert_status_zero_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_active && bus_addr == 2'd1) |-> bus_rdata[2:1] == 2'b00);

    assert_flag_needs_epp_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(epp_mode));

    assert_w1c_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_pulse && bus_addr == 2'd1 && bus_wdata[0] && !tmr_expire) |=> !flag_q);

    assert_ctrl_upper_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_active && bus_addr == 2'd2) |-> bus_rdata[7:6] == 2'b00);

    assert_idle_bus_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_active |-> bus_rdata == 8'h00);

endmodule

bind lpt_host_regs lpt_host_regs_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_addr      (bus_addr),
    .bus_wdata     (bus_wdata),
    .bus_rdata     (bus_rdata),
    .epp_mode      (epp_mode),
    .port_pins_in  (port_pins_in),
    .port_data_out (port_data_out),
    .rd_active     (rd_active),
    .wr_pulse      (wr_pulse),
    .tmr_expire    (tmr_expire),
    .flag_q        (flag_q)
);

// File: tb/lpt_host_regs_test.sv
module lpt_host_regs_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic       bus_rd_n = 1'b1;
    logic       bus_wr_n = 1'b1;
    logic [7:0] bus_rdata;
    logic       epp_mode = 1'b0;
    logic [7:0] port_pins_in = 8'h00;
    logic [7:0] port_data_out;
    logic       err_n_in = 1'b1;
    logic       select_in = 1'b0;
    logic       paper_end_in = 1'b0;
    logic       ack_n_in = 1'b1;
    logic       busy_in = 1'b0;
    logic [5:0] ctrl_out;
    logic       epp_cycle_start = 1'b0;
    logic       epp_cycle_done = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    lpt_host_regs uut (
        .clk             (clk),
        .rst_n           (rst_n),
        .bus_addr        (bus_addr),
        .bus_wdata       (bus_wdata),
        .bus_rd_n        (bus_rd_n),
        .bus_wr_n        (bus_wr_n),
        .bus_rdata       (bus_rdata),
        .epp_mode        (epp_mode),
        .port_pins_in    (port_pins_in),
        .port_data_out   (port_data_out),
        .err_n_in        (err_n_in),
        .select_in       (select_in),
        .paper_end_in    (paper_end_in),
        .ack_n_in        (ack_n_in),
        .busy_in         (busy_in),
        .ctrl_out        (ctrl_out),
        .epp_cycle_start (epp_cycle_start),
        .epp_cycle_done  (epp_cycle_done)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr_n  = 1'b0;
        wait_clk(4);
        bus_wr_n  = 1'b1;
        wait_clk(6);
    endtask

    task automatic rd_begin(input logic [1:0] a);
        @(negedge clk);
        bus_addr = a;
        bus_rd_n = 1'b0;
        wait_clk(5);
    endtask

    task automatic rd_end();
        bus_rd_n = 1'b1;
        wait_clk(5);
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        rd_begin(a);
        d = bus_rdata;
        rd_end();
    endtask

    task automatic pulse_start();
        @(negedge clk); epp_cycle_start = 1'b1;
        @(negedge clk); epp_cycle_start = 1'b0;
    endtask

    task automatic pulse_done();
        @(negedge clk); epp_cycle_done = 1'b1;
        @(negedge clk); epp_cycle_done = 1'b0;
    endtask

    function automatic logic [7:0] exp_status(input logic flag);
        return {~busy_in, ack_n_in, paper_end_in, select_in, err_n_in, 2'b00, flag};
    endfunction

    task automatic t_reset_state();
        logic [7:0] v;
        chk("R1 reset port_data_out", port_data_out, 8'h00);
        chk("R7 reset ctrl_out", {2'b00, ctrl_out}, 8'h00);
        chk("R9 idle rdata", bus_rdata, 8'h00);
        epp_mode = 1'b1;
        bus_read(2'd0, v);
        chk("R1 reset data reg", v, 8'h00);
        epp_mode = 1'b0;
        bus_read(2'd1, v);
        chk("R8 reset flag clear", v, exp_status(1'b0));
    endtask

    task automatic t_data_write();
        logic [7:0] v;
        bus_write(2'd0, 8'hA5);
        chk("R1 port_data_out after write", port_data_out, 8'hA5);
        bus_write(2'd0, 8'h3C);
        chk("R1 second write", port_data_out, 8'h3C);
        epp_mode = 1'b1;
        bus_read(2'd0, v);
        chk("R2 epp read returns register", v, 8'h3C);
        epp_mode = 1'b0;
    endtask

    task automatic t_spp_live();
        logic [7:0] v;
        port_pins_in = 8'h96;
        bus_read(2'd0, v);
        chk("R2 spp read returns pins", v, 8'h96);
        rd_begin(2'd0);
        chk("R10 live pins first", bus_rdata, 8'h96);
        port_pins_in = 8'h69;
        wait_clk(1);
        chk("R10 live pins follow", bus_rdata, 8'h69);
        rd_end();
    endtask

    task automatic t_status_map();
        logic [7:0] v;
        for (int i = 0; i < 5; i++) begin
            busy_in      = (i == 0);
            ack_n_in     = (i == 1);
            paper_end_in = (i == 2);
            select_in    = (i == 3);
            err_n_in     = (i == 4);
            bus_read(2'd1, v);
            chk("R4 status bit layout", v, exp_status(1'b0));
        end
        busy_in = 1'b0; ack_n_in = 1'b1; paper_end_in = 1'b0;
        select_in = 1'b1; err_n_in = 1'b1;
    endtask

    task automatic t_status_freeze();
        logic [7:0] a, b;
        busy_in = 1'b1; select_in = 1'b0;
        rd_begin(2'd1);
        a = bus_rdata;
        chk("R3 snapshot value", a, exp_status(1'b0));
        busy_in = 1'b0; select_in = 1'b1; paper_end_in = 1'b1;
        wait_clk(6);
        b = bus_rdata;
        chk("R3 snapshot held", b, a);
        rd_end();
        bus_read(2'd1, b);
        chk("R3 new read sees change", b, exp_status(1'b0));
        paper_end_in = 1'b0;
    endtask

    task automatic t_control();
        logic [7:0] v;
        bus_write(2'd2, 8'hFF);
        chk("R7 ctrl_out", {2'b00, ctrl_out}, 8'h3F);
        bus_read(2'd2, v);
        chk("R7 ctrl read upper zero", v, 8'h3F);
        bus_write(2'd2, 8'h15);
        bus_read(2'd2, v);
        chk("R7 ctrl pattern", v, 8'h15);
    endtask

    task automatic t_offset3();
        logic [7:0] v;
        bus_write(2'd3, 8'hEE);
        chk("R9 offset3 write no data change", port_data_out, 8'h3C);
        chk("R9 offset3 write no ctrl change", {2'b00, ctrl_out}, 8'h15);
        bus_read(2'd3, v);
        chk("R9 offset3 reads zero", v, 8'h00);
    endtask

    task automatic t_timeout_early();
        logic [7:0] v;
        epp_mode = 1'b1;
        pulse_start();
        wait_clk(2000);
        pulse_done();
        wait_clk(1000);
        bus_read(2'd1, v);
        chk("R5 early done no flag", {7'd0, v[0]}, 8'h00);
    endtask

    task automatic t_timeout_set_clear();
        logic [7:0] v;
        epp_mode = 1'b1;
        pulse_start();
        wait_clk(2600);
        bus_read(2'd1, v);
        chk("R5 timeout sets flag", {7'd0, v[0]}, 8'h01);
        bus_write(2'd1, 8'hFE);
        bus_read(2'd1, v);
        chk("R6 write zero keeps flag", {7'd0, v[0]}, 8'h01);
        bus_write(2'd1, 8'h01);
        bus_read(2'd1, v);
        chk("R6 write one clears flag", {7'd0, v[0]}, 8'h00);
        pulse_done();
    endtask

    task automatic t_timeout_spp();
        logic [7:0] v;
        epp_mode = 1'b0;
        pulse_start();
        wait_clk(2600);
        bus_read(2'd1, v);
        chk("R5 no flag in spp mode", {7'd0, v[0]}, 8'h00);
    endtask

    task automatic t_reset_clears();
        logic [7:0] v;
        epp_mode = 1'b1;
        pulse_start();
        wait_clk(2600);
        bus_read(2'd1, v);
        chk("R5 flag set before reset", {7'd0, v[0]}, 8'h01);
        @(negedge clk); rst_n = 1'b0;
        wait_clk(3);
        rst_n = 1'b1;
        wait_clk(3);
        chk("R8 data cleared", port_data_out, 8'h00);
        chk("R8 ctrl cleared", {2'b00, ctrl_out}, 8'h00);
        bus_read(2'd1, v);
        chk("R8 flag cleared", {7'd0, v[0]}, 8'h00);
    endtask

    initial begin
        wait_clk(4);
        rst_n = 1'b1;
        wait_clk(4);
        t_reset_state();
        t_data_write();
        t_spp_live();
        t_status_map();
        t_status_freeze();
        t_control();
        t_offset3();
        t_timeout_early();
        t_timeout_set_clear();
        t_timeout_spp();
        t_reset_clears();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule